// File: doc/BRIEF.md
# Transmit Buffer Read Arbiter

This block decides which of four clients may read from a shared transmit packet-buffer memory. The clients are a CPU port, a host-bus port, a read-DMA engine and a transmit MAC. Each client raises a request line. The arbiter then drives a one-hot grant. The granted client keeps the memory until it pulses a completion strobe.

A mode input selects between two policies.
- **Round-robin** rotates fairly among the clients. In this mode the read-DMA client is also held back while the downstream transmit FIFO reports that it is nearly empty. This lets the MAC refill the FIFO before it underruns.
- **Fixed-priority** serves the MAC first. It ignores the FIFO flag entirely.

The surrounding logic is expected to drive the mode input from a control register that defaults to round-robin.

Client encoding on the request and grant vectors:
- bit 0 = CPU
- bit 1 = host bus
- bit 2 = read DMA
- bit 3 = transmit MAC

Top module: `buf_rd_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle, and `gnt_o` is zero during and directly after reset.
- R2: When no grant is held, the arbiter decides on the clock edge that ends that cycle. The grant appears one cycle after the requests are presented, and only ever goes to a client whose `req_i` bit was high in the deciding cycle.
- R3: A grant stays unchanged for as long as `done_i` is low, whatever `req_i` does meanwhile.
- R4: A `done_i` pulse while a grant is held clears `gnt_o` on the next edge. The next decision is made in the following cycle. A `done_i` pulse while no grant is held has no effect.
- R5: In round-robin mode (`rr_mode_i`=1), the search starts at the client after the one last granted, in the order 0,1,2,3,0. Clients that are not requesting or are masked are skipped. The start position advances after every grant, in either mode.
- R6: After reset the round-robin start position is client 0 (CPU), so an all-request decision in round-robin mode grants bit 0.
- R7: In round-robin mode, while `fifo_aempty_i`=1, the read-DMA request (bit 2) cannot win. It becomes eligible again as soon as the flag is low at a decision.
- R8: In fixed-priority mode (`rr_mode_i`=0), the order is MAC (bit 3), then CPU (bit 0), then host bus (bit 1), then read DMA (bit 2). `fifo_aempty_i` is ignored.
- R9: The mode is used only at a decision. Changing `rr_mode_i` while a grant is held does not alter or drop that grant.
- R10: With no eligible request at a decision, `gnt_o` stays zero and the round-robin start position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-client read request |
| done_i | input | 1 | Completion strobe from the granted client |
| rr_mode_i | input | 1 | 1 = round-robin with DMA hold-off, 0 = fixed priority |
| fifo_aempty_i | input | 1 | Transmit FIFO almost-empty flag |
| gnt_o | output | 4 | One-hot grant |

## Verification
The bench builds the block with its default four clients and the default priority order, which keeps the input space small. It sweeps every one of the 16 request patterns under all four combinations of mode and FIFO flag, and repeats that sweep so that the round-robin start position passes through every value. In this way each request pattern meets several pointer positions. A bench-side model computes the winner arithmetically. Every granted transfer is also held across a request drop and a mode flip, and stray completion strobes and a mid-run reset check the pointer's return to the CPU position.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} bra_state_e;
endpackage

// File: rtl/bra_rr_pick.sv
module bra_rr_pick #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // search starts at ptr_i, wraps around
  always_comb begin
    int unsigned j;
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int unsigned k = 0; k < N_REQ; k++) begin
      j = (int'(ptr_i) + k) % N_REQ;
      if (!any_o && req_i[j]) begin
        any_o    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/bra_prio_pick.sv
module bra_prio_pick #(
  parameter int unsigned            N_REQ = 4,
  parameter int unsigned            IDX_W = $clog2(N_REQ),
  parameter logic [N_REQ*IDX_W-1:0] ORDER = 8'b10_01_00_11
) (
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // rank 0 in the low field of ORDER is highest priority
  logic [IDX_W-1:0] rank_idx [N_REQ];

  for (genvar r = 0; r < N_REQ; r++) begin : g_rank
    assign rank_idx[r] = ORDER[r*IDX_W +: IDX_W];
  end

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int unsigned r = 0; r < N_REQ; r++) begin
      if (!any_o && req_i[rank_idx[r]]) begin
        any_o              = 1'b1;
        gnt_o[rank_idx[r]] = 1'b1;
        idx_o              = rank_idx[r];
      end
    end
  end
endmodule

// File: rtl/buf_rd_arbiter.sv
module buf_rd_arbiter #(
  parameter int unsigned              N_REQ   = 4,
  parameter int unsigned              DMA_IDX = 2,
  parameter logic [N_REQ*$clog2(N_REQ)-1:0] ORDER = 8'b10_01_00_11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             done_i,
  input  logic             rr_mode_i,
  input  logic             fifo_aempty_i,
  output logic [N_REQ-1:0] gnt_o
);
  import bra_pkg::*;

  localparam int unsigned IDX_W = $clog2(N_REQ);
  localparam logic [N_REQ-1:0] DMA_BIT = N_REQ'(1) << DMA_IDX;

  bra_state_e       st_q;
  logic [N_REQ-1:0] gnt_q;
  logic [IDX_W-1:0] ptr_q;

  logic [N_REQ-1:0] elig;
  logic [N_REQ-1:0] rr_gnt, pr_gnt, pick_gnt;
  logic [IDX_W-1:0] rr_idx, pr_idx, pick_idx;
  logic             rr_any, pr_any, pick_any;

  // DMA hold-off only in round-robin mode
  assign elig = req_i & ~((rr_mode_i && fifo_aempty_i) ? DMA_BIT : '0);

  bra_rr_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_rr (
    .req_i (elig),
    .ptr_i (ptr_q),
    .gnt_o (rr_gnt),
    .idx_o (rr_idx),
    .any_o (rr_any)
  );

  bra_prio_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W), .ORDER(ORDER)) u_pr (
    .req_i (elig),
    .gnt_o (pr_gnt),
    .idx_o (pr_idx),
    .any_o (pr_any)
  );

  assign pick_gnt = rr_mode_i ? rr_gnt : pr_gnt;
  assign pick_idx = rr_mode_i ? rr_idx : pr_idx;
  assign pick_any = rr_mode_i ? rr_any : pr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      gnt_q <= '0;
      ptr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pick_any) begin
          gnt_q <= pick_gnt;
          ptr_q <= (pick_idx == IDX_W'(N_REQ-1)) ? '0 : pick_idx + 1'b1;
          st_q  <= ST_BUSY;
        end
        ST_BUSY: if (done_i) begin
          gnt_q <= '0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_o = gnt_q;

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r2_gnt_to_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> ((gnt_o & ~$past(req_i)) == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !done_i) |=> (gnt_o == $past(gnt_o)));
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && done_i) |=> (gnt_o == '0));
  a_r7_dma_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && rr_mode_i && fifo_aempty_i) |=> !gnt_o[DMA_IDX]);
  a_r10_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));
endmodule

// File: tb/sim_buf_rd_arbiter.sv
module sim_buf_rd_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] req_i;
  logic       done_i;
  logic       rr_mode_i;
  logic       fifo_aempty_i;
  logic [3:0] gnt_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  int ptr_m  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_rd_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .done_i(done_i),
    .rr_mode_i(rr_mode_i), .fifo_aempty_i(fifo_aempty_i), .gnt_o(gnt_o)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  // bit0 CPU, bit1 host, bit2 DMA, bit3 MAC
  function automatic logic [3:0] model(input logic [3:0] rq, input bit md, input bit ae, input int p);
    logic [3:0] el;
    int ord [4];
    el = rq & ~((md && ae) ? 4'b0100 : 4'b0000);
    if (md) begin
      for (int k = 0; k < 4; k++) ord[k] = (p + k) % 4;
    end else begin
      ord[0] = 3; ord[1] = 0; ord[2] = 1; ord[3] = 2;
    end
    for (int k = 0; k < 4; k++)
      if (el[ord[k]]) return 4'b0001 << ord[k];
    return 4'b0000;
  endfunction

  task automatic arbitrate(input logic [3:0] rq, input bit md, input bit ae, input string tag_over);
    logic [3:0] exp;
    string tag;
    req_i = rq; rr_mode_i = md; fifo_aempty_i = ae;
    exp = model(rq, md, ae, ptr_m);
    tag = (exp == 0) ? "R10" : (md ? (ae ? "R7" : "R5") : "R8");
    if (tag_over != "") tag = tag_over;
    @(negedge clk);
    check(gnt_o === exp, tag, gnt_o, exp);
    check((gnt_o & ~rq) == 0 && $countones(gnt_o) <= 1, "R2/R1", gnt_o, exp);
    if (exp != 0) begin
      for (int i = 0; i < 4; i++) if (exp[i]) ptr_m = (i + 1) % 4;
      req_i = 4'b0000; rr_mode_i = ~md;
      @(negedge clk);
      check(gnt_o === exp, "R3/R9", gnt_o, exp);
      done_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0;
      check(gnt_o === 4'b0000, "R4", gnt_o, 4'b0000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL watchdog: gnt=%b expected=done", gnt_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req_i = 4'hF; done_i = 1'b0; rr_mode_i = 1'b1; fifo_aempty_i = 1'b0;
    repeat (3) @(negedge clk);
    check(gnt_o === 4'b0000, "R1", gnt_o, 4'b0000);
    rst_ni = 1'b1;
    ptr_m = 0;
    arbitrate(4'hF, 1'b1, 1'b0, "R6");

    // stray done while idle
    req_i = 4'b0000; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check(gnt_o === 4'b0000, "R4", gnt_o, 4'b0000);
    arbitrate(4'hF, 1'b1, 1'b0, "R5");

    // R7 release: DMA only, flag drops
    arbitrate(4'b0100, 1'b1, 1'b1, "R7");
    arbitrate(4'b0100, 1'b1, 1'b0, "R7");
    // R8 flag ignored in fixed mode
    arbitrate(4'b0100, 1'b0, 1'b1, "R8");

    for (int pass = 0; pass < 4; pass++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 16; r++)
          arbitrate(4'(r + pass * 5), m[1], m[0], "");

    // reset returns pointer to CPU
    rst_ni = 1'b0;
    @(negedge clk);
    check(gnt_o === 4'b0000, "R1", gnt_o, 4'b0000);
    rst_ni = 1'b1;
    ptr_m = 0;
    arbitrate(4'hF, 1'b1, 1'b0, "R6");

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule